// File: doc/BRIEF.md
# Unaligned write burst packer

The packer sits in front of the write side of a DDR2-style memory controller user port. A client hands it one write request: a start address counted in 32-bit words, a word count, and then the words themselves on a ready/valid stream. The packer groups the words into aligned four-word bursts. Each burst goes out as two 64-bit beats, and each beat carries a byte mask. Every word lands in the slot that its address selects inside its aligned group of four. Slots that no word of the request covers are blocked through the mask. Because of this, neither the start nor the end of a request has to sit on a burst boundary.

Each burst presents its aligned address together with an address strobe on its first beat. The second beat raises only the data strobe. One shared ready input from the controller accepts each beat. When the last beat has been accepted, the packer pulses a done output and returns to idle for the next request. A request with a count of zero completes without producing any beat.

Top module: `wr_burst_packer`

## Requirements
- R1: Whenever a beat is offered, `mem_addr` is a word address whose two least significant bits are zero.
- R2: Every burst is exactly two beats that carry the same address. `mem_avalid` is high with the first beat and low with the second, and `mem_wvalid` is high on both.
- R3: A word with address A travels in the burst at A with its two low bits cleared. It uses beat (A mod 4) div 2, and within that beat it uses lane A mod 2. Lane 0 is `mem_wdata[31:0]` with mask bits [3:0], and lane 1 is `mem_wdata[63:32]` with mask bits [7:4].
- R4: A mask bit of 1 blocks its byte. The four mask bits of a lane are either all 0 (lane written) or all 1 (lane blocked). In the first burst, every slot below the start offset is blocked.
- R5: Slots after the last word of the request are blocked. When the last word falls in beat 0, beat 1 is still sent, with mask 0xFF.
- R6: The bursts of one request start at the start address with its low bits cleared and rise by 4 per burst. One burst is sent for each aligned group of four that the request touches.
- R7: A request with a count of zero produces no beat, and `done` is high in the cycle after that request is accepted.
- R8: While a beat is offered and `mem_ready` is low, the beat's data, mask, address and strobes hold in the next cycle. No input word is accepted while a beat is offered.
- R9: Exactly `req_count` input words are accepted. `done` is high for the single cycle that follows the acceptance of the last beat and is low at every other time during a request.
- R10: `req_ready` is high when the packer is idle, including after reset. It is low from the cycle after a non-zero request is accepted until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Packer idle, request accepted when valid |
| req_addr | input | ADDR_W | Start address in words |
| req_count | input | CNT_W | Number of words in the request |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken when valid |
| in_data | input | WORD_W | Input word |
| mem_ready | input | 1 | Controller accepts the offered beat |
| mem_wvalid | output | 1 | Data strobe: a beat is offered |
| mem_avalid | output | 1 | Address strobe: first beat of a burst |
| mem_addr | output | ADDR_W | Aligned burst word address |
| mem_wdata | output | WORD_W*BEAT_WORDS | Beat data, even slot in the low lane |
| mem_mask | output | WORD_W*BEAT_WORDS/8 | Byte mask, 1 blocks the byte |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bound checker watches these rules on every cycle:
- burst alignment;
- the pairing of the address strobe with the first beat;
- a constant address across the two beats of a burst;
- the step of 4 between successive burst addresses;
- lane-uniform masks;
- holding the beat under backpressure, with input stalled meanwhile;
- `req_ready` dropping once a request is taken;
- the done pulse after a zero-length request.

Other properties depend on the request as a whole, and only the bench's scenarios can show them:
- the slot each word lands in;
- which slots are blocked at the leading and trailing ends;
- the extra fully masked beat;
- the number of bursts and of accepted words;
- the exact cycle of `done`.

The bench computes these from the start offset and the count across all four offsets, several lengths, address-space top values and three stall patterns.

// File: rtl/wbp_pkg.sv
`timescale 1ns/1ps
// Shared types of the write burst packer.
package wbp_pkg;
    // Control states: waiting for a request, filling a beat, offering a beat.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ISSUE = 2'd2
    } wbp_state_e;
endpackage

// File: rtl/wbp_addr_track.sv
`timescale 1ns/1ps
// Address and count tracker.
// Holds the address of the next word to place, the number of words still to
// come and the aligned base address of the burst being built.
// Assumes: load, take and step are never asserted in the same cycle as each
// other (load only in idle, take only while filling, step only while issuing).
module wbp_addr_track #(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 12,
    parameter int BURST_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              take,
    input  logic              step,
    output logic [ADDR_W-1:0] word_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic [ADDR_W-1:0] burst_base
);
    localparam int OFF_W = $clog2(BURST_WORDS);

    // Next-word pointer and remaining count: loaded per request, advanced per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_addr <= '0;
            remaining <= '0;
        end else if (load) begin
            word_addr <= load_addr;
            remaining <= load_count;
        end else if (take) begin
            word_addr <= word_addr + ADDR_W'(1);
            remaining <= remaining - CNT_W'(1);
        end
    end

    // Burst base: start address with offset bits cleared, stepped by one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_base <= '0;
        end else if (load) begin
            burst_base <= {load_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end else if (step) begin
            burst_base <= burst_base + ADDR_W'(BURST_WORDS);
        end
    end
endmodule

// File: rtl/wbp_beat_build.sv
`timescale 1ns/1ps
// Beat assembler.
// One data and mask register per lane of the output beat. Clearing sets every
// lane to zero data with all of its mask bits set (blocked); writing a lane
// stores the word and opens its mask bits.
// Assumes: clear and wr_en are not asserted together.
module wbp_beat_build #(
    parameter int WORD_W     = 32,
    parameter int BEAT_WORDS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             wr_en,
    input  logic [$clog2(BEAT_WORDS)-1:0]    lane,
    input  logic [WORD_W-1:0]                wr_word,
    output logic [WORD_W*BEAT_WORDS-1:0]     beat_data,
    output logic [WORD_W*BEAT_WORDS/8-1:0]   beat_mask
);
    localparam int LANE_W = $clog2(BEAT_WORDS);
    localparam int LB     = WORD_W / 8;

    for (genvar g = 0; g < BEAT_WORDS; g++) begin : g_lane
        // Lane register: blocked after clear, opened when its word arrives.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                beat_data[g*WORD_W +: WORD_W] <= '0;
                beat_mask[g*LB +: LB]         <= '1;
            end else if (wr_en && lane == LANE_W'(g)) begin
                beat_data[g*WORD_W +: WORD_W] <= wr_word;
                beat_mask[g*LB +: LB]         <= '0;
            end
        end
    end
endmodule

// File: rtl/wbp_seq.sv
`timescale 1ns/1ps
// Sequencer of the write burst packer.
// Walks the slots of each burst in order, one slot per cycle. A slot whose
// offset equals the offset of the next word takes an input word; any other
// slot is skipped and stays blocked. After the last lane of a beat the beat is
// offered until the controller takes it. The first beat carries the address
// strobe. After the last beat of a burst the sequencer starts the next burst
// or, with no words left, finishes with a done pulse.
// Assumes: BURST_WORDS and BEAT_WORDS are powers of two, both at least 2.
module wbp_seq
    import wbp_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int BURST_WORDS = 4,
    parameter int BEAT_WORDS  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [CNT_W-1:0]                  req_count,
    output logic                              req_ready,
    input  logic [$clog2(BURST_WORDS)-1:0]    word_off,
    input  logic [CNT_W-1:0]                  remaining,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic                              mem_ready,
    output logic                              load,
    output logic                              take,
    output logic                              step,
    output logic                              clear,
    output logic [$clog2(BEAT_WORDS)-1:0]     lane,
    output logic                              mem_wvalid,
    output logic                              mem_avalid,
    output logic                              done
);
    localparam int BEATS  = BURST_WORDS / BEAT_WORDS;
    localparam int LANE_W = $clog2(BEAT_WORDS);
    localparam int BIDX_W = $clog2(BEATS);
    localparam int OFF_W  = LANE_W + BIDX_W;

    wbp_state_e        state;
    logic [BIDX_W-1:0] beat_idx;
    logic [LANE_W-1:0] lane_idx;
    logic [OFF_W-1:0]  slot_off;
    logic              rem_zero, slot_hit, advance, req_fire, beat_fire;
    logic              lane_last, beat_last;

    // Slot decode and handshakes of the current cycle.
    always_comb begin
        slot_off   = {beat_idx, lane_idx};
        rem_zero   = (remaining == '0);
        lane_last  = (lane_idx == LANE_W'(BEAT_WORDS - 1));
        beat_last  = (beat_idx == BIDX_W'(BEATS - 1));
        slot_hit   = (state == ST_FILL) && !rem_zero && (word_off == slot_off);
        advance    = (state == ST_FILL) && (!slot_hit || in_valid);
        req_ready  = (state == ST_IDLE);
        req_fire   = req_ready && req_valid;
        beat_fire  = (state == ST_ISSUE) && mem_ready;
        in_ready   = slot_hit;
        take       = slot_hit && in_valid;
        load       = req_fire;
        clear      = req_fire || beat_fire;
        step       = beat_fire && beat_last && !rem_zero;
        lane       = lane_idx;
        mem_wvalid = (state == ST_ISSUE);
        mem_avalid = (state == ST_ISSUE) && (beat_idx == '0);
    end

    // State, beat and lane counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat_idx <= '0;
            lane_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    beat_idx <= '0;
                    lane_idx <= '0;
                    if (req_fire && req_count != '0) state <= ST_FILL;
                end
                ST_FILL: begin
                    if (advance) begin
                        if (lane_last) begin
                            lane_idx <= '0;
                            state    <= ST_ISSUE;
                        end else begin
                            lane_idx <= lane_idx + LANE_W'(1);
                        end
                    end
                end
                ST_ISSUE: begin
                    if (beat_fire) begin
                        if (!beat_last) begin
                            beat_idx <= beat_idx + BIDX_W'(1);
                            state    <= ST_FILL;
                        end else begin
                            beat_idx <= '0;
                            state    <= rem_zero ? ST_IDLE : ST_FILL;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse: after an empty request or after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (req_fire && req_count == '0) ||
                    (beat_fire && beat_last && rem_zero);
        end
    end
endmodule

// File: rtl/wr_burst_packer.sv
`timescale 1ns/1ps
// Unaligned write burst packer, top level.
// Turns a word-addressed write request of any start and length into aligned
// bursts of BURST_WORDS words, sent as beats of BEAT_WORDS words with a byte
// mask (1 = blocked). Words sit at the slot their address selects; all other
// slots are blocked.
// Assumes: the request's word stream delivers exactly req_count words.
module wr_burst_packer #(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 12,
    parameter int WORD_W      = 32,
    parameter int BEAT_WORDS  = 2,
    parameter int BURST_WORDS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [CNT_W-1:0]                req_count,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [WORD_W-1:0]               in_data,
    input  logic                            mem_ready,
    output logic                            mem_wvalid,
    output logic                            mem_avalid,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [WORD_W*BEAT_WORDS-1:0]    mem_wdata,
    output logic [WORD_W*BEAT_WORDS/8-1:0]  mem_mask,
    output logic                            done
);
    localparam int OFF_W  = $clog2(BURST_WORDS);
    localparam int LANE_W = $clog2(BEAT_WORDS);

    logic              load, take, step, clear;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] word_addr;
    logic [CNT_W-1:0]  remaining;

    wbp_addr_track #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_WORDS(BURST_WORDS)
    ) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_addr(req_addr), .load_count(req_count),
        .take(take), .step(step),
        .word_addr(word_addr), .remaining(remaining), .burst_base(mem_addr)
    );

    wbp_seq #(
        .CNT_W(CNT_W), .BURST_WORDS(BURST_WORDS), .BEAT_WORDS(BEAT_WORDS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_count(req_count), .req_ready(req_ready),
        .word_off(word_addr[OFF_W-1:0]), .remaining(remaining),
        .in_valid(in_valid), .in_ready(in_ready), .mem_ready(mem_ready),
        .load(load), .take(take), .step(step), .clear(clear), .lane(lane),
        .mem_wvalid(mem_wvalid), .mem_avalid(mem_avalid), .done(done)
    );

    wbp_beat_build #(
        .WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS)
    ) u_beat (
        .clk(clk), .rst_n(rst_n),
        .clear(clear), .wr_en(take), .lane(lane), .wr_word(in_data),
        .beat_data(mem_wdata), .beat_mask(mem_mask)
    );
endmodule

// File: rtl/wbp_checker.sv
`timescale 1ns/1ps
// Protocol checker for wr_burst_packer, bound to every instance.
// Tracks which beat of a burst is due, the address of the open burst and the
// address of the previous burst of the request.
module wbp_checker #(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 12,
    parameter int WORD_W      = 32,
    parameter int BEAT_WORDS  = 2,
    parameter int BURST_WORDS = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            req_ready,
    input logic [CNT_W-1:0]                req_count,
    input logic                            in_ready,
    input logic                            mem_ready,
    input logic                            mem_wvalid,
    input logic                            mem_avalid,
    input logic [ADDR_W-1:0]               mem_addr,
    input logic [WORD_W*BEAT_WORDS-1:0]    mem_wdata,
    input logic [WORD_W*BEAT_WORDS/8-1:0]  mem_mask,
    input logic                            done
);
    localparam int LB    = WORD_W / 8;
    localparam int OFF_W = $clog2(BURST_WORDS);

    logic              first_due, have_prev;
    logic [ADDR_W-1:0] open_addr, prev_addr;
    logic              fire;

    assign fire = mem_wvalid && mem_ready;

    // Expected beat position and burst address history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_due <= 1'b1;
            have_prev <= 1'b0;
            open_addr <= '0;
            prev_addr <= '0;
        end else begin
            if (fire) first_due <= !first_due;
            if (fire && mem_avalid) begin
                open_addr <= mem_addr;
                prev_addr <= mem_addr;
                have_prev <= 1'b1;
            end else if (done) begin
                have_prev <= 1'b0;
            end
        end
    end

    assert_burst_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_addr[OFF_W-1:0] == '0));

    assert_addr_strobe_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_avalid == first_due));

    assert_addr_strobe_with_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_avalid |-> mem_wvalid);

    assert_second_beat_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_avalid) |-> (mem_addr == open_addr));

    for (genvar g = 0; g < BEAT_WORDS; g++) begin : g_lane
        assert_lane_mask_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wvalid |-> ((mem_mask[g*LB +: LB] == '0) || (mem_mask[g*LB +: LB] == '1)));
    end

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && mem_avalid && have_prev) |-> (mem_addr == prev_addr + ADDR_W'(BURST_WORDS)));

    assert_empty_request_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count == '0) |=> done);

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_ready) |=> (mem_wvalid && $stable(mem_wdata) && $stable(mem_mask)
                                        && $stable(mem_addr) && $stable(mem_avalid)));

    assert_no_input_while_offering_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> !in_ready);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_count != '0) |=> !req_ready);
endmodule

bind wr_burst_packer wbp_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_W(WORD_W),
    .BEAT_WORDS(BEAT_WORDS), .BURST_WORDS(BURST_WORDS)
) u_wbp_checker (.*);

// File: tb/sim_wr_burst_packer.sv
`timescale 1ns/1ps
// Bench: sweeps start offset, length and stall pattern; expected beats are
// computed from the request arithmetic alone.
module sim_wr_burst_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [11:0] req_count = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        mem_ready = 1'b0;
    logic        mem_wvalid, mem_avalid;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_mask;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wr_burst_packer u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_count(req_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .mem_ready(mem_ready), .mem_wvalid(mem_wvalid), .mem_avalid(mem_avalid),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_mask(mem_mask), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wd(input int a, input int k);
        return {8'hC3, 8'(a), 16'(k)};
    endfunction

    // One request; mode 0 = no stalls, 1 = light stalls, 2 = heavy stalls.
    task automatic run_req(input int a, input int n, input int mode);
        int widx = 0;
        int bidx = 0;
        int cyc = 0;
        int nb;
        bit expect_done = 0;
        bit held = 0;
        logic [63:0] h_data;
        logic [7:0]  h_mask;
        logic [15:0] h_addr;
        logic        h_av;
        nb = (n == 0) ? 0 : ((((a + n - 1) >> 2) - (a >> 2)) + 1) * 2;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'(a); req_count = 12'(n);
        #1;
        chk(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) expect_done = 1;
        while (1) begin
            if (expect_done) begin
                chk(done == 1'b1, (n == 0) ? "R7" : "R9", "done pulse", done, 1);
                break;
            end
            chk(done == 1'b0, "R9", "done early", done, 0);
            chk(req_ready == 1'b0, "R10", "busy", req_ready, 0);
            if (held) begin
                chk(mem_wvalid && mem_wdata == h_data && mem_mask == h_mask &&
                    mem_addr == h_addr && mem_avalid == h_av, "R8", "hold beat",
                    {mem_wvalid, mem_mask, mem_addr}, {1'b1, h_mask, h_addr});
                held = 0;
            end
            if (mem_wvalid) chk(in_ready == 1'b0, "R8", "input while offering", in_ready, 0);
            case (mode)
                0: begin mem_ready = 1'b1; in_valid = (widx < n); end
                1: begin mem_ready = (cyc % 3 != 1); in_valid = (widx < n) && (cyc % 4 != 2); end
                default: begin mem_ready = (cyc % 2 == 0); in_valid = (widx < n) && (cyc % 3 != 0); end
            endcase
            in_data = wd(a, widx);
            #1;
            if (in_valid && in_ready) widx++;
            if (mem_wvalid && !mem_ready) begin
                held = 1; h_data = mem_wdata; h_mask = mem_mask; h_addr = mem_addr; h_av = mem_avalid;
            end
            if (mem_wvalid && mem_ready) begin
                int base = ((a >> 2) << 2) + 4 * (bidx / 2);
                int j = bidx % 2;
                logic [7:0] emask;
                for (int l = 0; l < 2; l++) begin
                    int sa = base + 2 * j + l;
                    bit inr = (sa >= a) && (sa < a + n);
                    emask[4*l +: 4] = inr ? 4'h0 : 4'hF;
                    if (inr) chk(mem_wdata[32*l +: 32] == wd(a, sa - a), "R3", "slot data",
                                 mem_wdata[32*l +: 32], wd(a, sa - a));
                end
                chk(bidx < nb, "R6", "extra beat", bidx, nb);
                chk(mem_mask == emask, "R4,R5", "mask", mem_mask, emask);
                chk(mem_addr == 16'(base), "R6", "burst address", mem_addr, 16'(base));
                chk(mem_avalid == (j == 0), "R2", "address strobe", mem_avalid, (j == 0));
                if (bidx == nb - 1) expect_done = 1;
                bidx++;
            end
            cyc++;
            if (cyc > 500) begin
                chk(0, "R9", "request timeout", cyc, 500);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        mem_ready = 1'b0;
        chk(widx == n, "R9", "words accepted", widx, n);
        chk(bidx == nb, "R6", "beat count", bidx, nb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_wvalid == 1'b0 && mem_avalid == 1'b0, "R2", "reset strobes", {mem_wvalid, mem_avalid}, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(req_ready == 1'b1 && in_ready == 1'b0, "R10", "reset ready", {req_ready, in_ready}, 2);
        // Near-exhaustive sweep of start offsets and lengths.
        for (int a = 0; a < 8; a++)
            for (int n = 0; n < 10; n++)
                run_req(a + 32, n, (a + n) % 3);
        // Longer spans, top of the address space, empty back-to-back.
        run_req(13, 17, 1);
        run_req(14, 22, 2);
        run_req(16'hFFF9, 6, 0);
        run_req(16'hFFFD, 3, 2);
        run_req(5, 0, 0);
        run_req(6, 0, 1);
        run_req(3, 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule